// File: doc/BRIEF.md
# Receive Descriptor Frame Writer

This block sits on the DMA side of an Ethernet receive path. A frame arrives as a payload byte count. The CRC is computed elsewhere, and its four bytes are appended to the frame as its tail. The block works out the stored size and decides how the bytes spread over a ring of receive buffer descriptors. For each descriptor it emits one writeback record: the length, the number of CRC bytes in that buffer, the leading pad marker, the last marker and the error flags. A separate memory subsystem moves the data and updates the descriptor words.

The stored size can be reduced in two ways. A hard truncation limit clips the size, and the truncation is reported. A softer limit, taken from bits 31:16 of the receive control word, only marks the frame as too long. An optional alignment mode puts two zero bytes in front of the first buffer. After the last descriptor of a frame, the ring pointer moves on. The receive-active flag is then reloaded from the empty bit of the descriptor that the pointer now selects. If a filled descriptor is reached partway through a frame, the rest of that frame is dropped.

Top module: `rx_desc_writer`

## Requirements
- R1: A frame request is taken only when the block is idle and receive-active is 1. A request at any other time produces no writeback and leaves the descriptor index unchanged.
- R2: The stored size is the payload length plus 4, plus 2 more when the alignment mode is on. If that size is above `trunc_lim_i`, the size becomes `trunc_lim_i`, and the last descriptor reports both truncated and too-long.
- R3: A stored size (after clipping) above `rx_lim_i` sets only too-long. A size equal to the limit sets neither flag.
- R4: Each descriptor gets min(remaining, buffer size) bytes. The buffer size is `max_buf_i` with bits 3:0 cleared (bits 13:4 kept). A result of zero is treated as 16 bytes.
- R5: The final 4 bytes of the stored size are CRC bytes. `wb_crc_o` gives how many of them fall into the current descriptor, so a 1-byte last buffer reports 1.
- R6: In alignment mode, `wb_pad_o` is 1 on the first descriptor of the frame only. The pad bytes are counted in that descriptor's length.
- R7: `wb_last_o`, `wb_trunc_o` and `wb_long_o` can be 1 only on the final descriptor of a frame. `irq_rxf_o` pulses with the final descriptor. `irq_rxb_o` pulses with every descriptor writeback.
- R8: After a writeback, the index goes to 0 if the descriptor's wrap bit is set or it is the last ring slot. Otherwise the index goes up by 1.
- R9: After a frame ends, receive-active takes the empty bit of the descriptor now selected. `arm_i` while idle loads receive-active the same way.
- R10: If a descriptor without the empty bit is reached in a frame, `lost_o` pulses and no writeback is made for it. The rest of the frame is dropped, receive-active ends at 0, and the index stays on that descriptor.
- R11: After reset the block is idle, receive-active is 0, the index is 0 and no writeback is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | Request to store one frame |
| frame_len_i | input | LEN_W | Payload bytes, CRC excluded |
| shift16_i | input | 1 | Alignment mode: two zero bytes ahead of the data |
| trunc_lim_i | input | LEN_W | Hard size limit; reset value of the source register is 0x7FF |
| rx_lim_i | input | 16 | Soft limit, bits 31:16 of the receive control word (0x05EE after reset) |
| max_buf_i | input | 14 | Buffer size, bits 13:4 used |
| arm_i | input | 1 | Reload receive-active from the current descriptor |
| desc_empty_i | input | 1 | Empty bit of the selected descriptor |
| desc_wrap_i | input | 1 | Wrap bit of the selected descriptor |
| desc_idx_o | output | log2(DEPTH) | Selected descriptor |
| busy_o | output | 1 | Frame in progress |
| rx_active_o | output | 1 | Receive-active flag |
| wb_valid_o | output | 1 | Writeback of the selected descriptor this cycle |
| wb_len_o | output | LEN_W+2 | Bytes in this buffer |
| wb_crc_o | output | 3 | CRC bytes in this buffer |
| wb_pad_o | output | 1 | Buffer starts with the two pad bytes |
| wb_last_o | output | 1 | Last buffer of the frame |
| wb_trunc_o | output | 1 | Frame was truncated |
| wb_long_o | output | 1 | Frame above a limit |
| irq_rxb_o | output | 1 | Buffer-done interrupt pulse |
| irq_rxf_o | output | 1 | Frame-done interrupt pulse |
| lost_o | output | 1 | Filled descriptor met partway through a frame |

## Verification
Take the edge at which a request is sampled. The first writeback, or a `lost_o` pulse, is due in the cycle right after that edge, and each later descriptor follows one cycle after the one before. After the final writeback comes one settling cycle. At its closing edge receive-active and `busy_o` update, so both are read in the cycle after it. The bench drives on falling edges and samples every writeback field at the falling edge of each busy cycle, which keeps the reads between register updates. Receive-active after `arm_i` is read one cycle after the arming edge.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_ARM} rxw_state_e;
  typedef struct packed {
    logic trunc;
    logic too_long;
  } rxw_err_t;
endpackage

// File: rtl/rxw_sizer.sv
module rxw_sizer import rxw_pkg::*; #(
  parameter int LEN_W = 16,
  localparam int SZ_W = LEN_W + 2
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic             shift16_i,
  input  logic [LEN_W-1:0] trunc_lim_i,
  input  logic [15:0]      soft_lim_i,
  output logic [SZ_W-1:0]  size_o,
  output rxw_err_t         err_o
);
  logic [SZ_W-1:0] raw;
  always_comb begin
    raw = SZ_W'(len_i) + SZ_W'(4) + (shift16_i ? SZ_W'(2) : SZ_W'(0));
    err_o.trunc = raw > SZ_W'(trunc_lim_i);
    size_o = err_o.trunc ? SZ_W'(trunc_lim_i) : raw;
    err_o.too_long = err_o.trunc | (size_o > SZ_W'(soft_lim_i));
  end
endmodule

// File: rtl/rxw_splitter.sv
module rxw_splitter #(
  parameter int SZ_W = 18
) (
  input  logic [SZ_W-1:0] rem_i,
  input  logic [13:0]     max_buf_i,
  output logic [SZ_W-1:0] eff_o,
  output logic [SZ_W-1:0] len_o,
  output logic [SZ_W-1:0] after_o,
  output logic [2:0]      crc_o,
  output logic            last_o
);
  logic [13:0] mb_al;
  logic [2:0]  need;
  always_comb begin
    mb_al   = max_buf_i & 14'h3FF0;
    eff_o   = (mb_al == 14'd0) ? SZ_W'(16) : SZ_W'(mb_al);
    len_o   = (rem_i < eff_o) ? rem_i : eff_o;
    after_o = rem_i - len_o;
    last_o  = (after_o == '0);
    need    = 3'd0;
    crc_o   = 3'd0;
    if (after_o < SZ_W'(4)) begin
      need  = 3'(SZ_W'(4) - after_o);
      crc_o = (SZ_W'(need) > len_o) ? 3'(len_o) : need;
    end
  end
endmodule

// File: rtl/rxw_ring.sv
module rxw_ring #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wrap_i,
  input  logic             load_i,
  input  logic             empty_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o    <= '0;
      active_o <= 1'b0;
    end else begin
      if (adv_i)
        idx_o <= (wrap_i || idx_o == IDX_W'(DEPTH-1)) ? '0 : idx_o + 1'b1;
      if (load_i)
        active_o <= empty_i;
    end
  end

  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i) |=> (idx_o == '0));
  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_i && idx_o != IDX_W'(DEPTH-1)) |=> (idx_o == $past(idx_o) + 1'b1));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(idx_o));
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer import rxw_pkg::*; #(
  parameter int LEN_W = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_valid_i,
  input  logic [LEN_W-1:0]         frame_len_i,
  input  logic                     shift16_i,
  input  logic [LEN_W-1:0]         trunc_lim_i,
  input  logic [15:0]              rx_lim_i,
  input  logic [13:0]              max_buf_i,
  input  logic                     arm_i,
  input  logic                     desc_empty_i,
  input  logic                     desc_wrap_i,
  output logic [$clog2(DEPTH)-1:0] desc_idx_o,
  output logic                     busy_o,
  output logic                     rx_active_o,
  output logic                     wb_valid_o,
  output logic [LEN_W+1:0]         wb_len_o,
  output logic [2:0]               wb_crc_o,
  output logic                     wb_pad_o,
  output logic                     wb_last_o,
  output logic                     wb_trunc_o,
  output logic                     wb_long_o,
  output logic                     irq_rxb_o,
  output logic                     irq_rxf_o,
  output logic                     lost_o
);
  localparam int SZ_W = LEN_W + 2;

  rxw_state_e      state_q;
  logic [SZ_W-1:0] rem_q, size_w, eff_w, after_w;
  rxw_err_t        err_q, err_w;
  logic            pad_q, last_w, accept, writing;

  rxw_sizer #(.LEN_W(LEN_W)) u_sizer (
    .len_i(frame_len_i), .shift16_i(shift16_i), .trunc_lim_i(trunc_lim_i),
    .soft_lim_i(rx_lim_i), .size_o(size_w), .err_o(err_w));

  rxw_splitter #(.SZ_W(SZ_W)) u_split (
    .rem_i(rem_q), .max_buf_i(max_buf_i), .eff_o(eff_w), .len_o(wb_len_o),
    .after_o(after_w), .crc_o(wb_crc_o), .last_o(last_w));

  rxw_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wb_valid_o), .wrap_i(desc_wrap_i),
    .load_i((state_q == ST_ARM) || (state_q == ST_IDLE && arm_i)),
    .empty_i(desc_empty_i), .idx_o(desc_idx_o), .active_o(rx_active_o));

  assign accept     = (state_q == ST_IDLE) && frame_valid_i && rx_active_o;
  assign writing    = (state_q == ST_WRITE);
  assign wb_valid_o = writing && desc_empty_i;
  assign lost_o     = writing && !desc_empty_i;
  assign wb_last_o  = wb_valid_o && last_w;
  assign wb_trunc_o = wb_last_o && err_q.trunc;
  assign wb_long_o  = wb_last_o && err_q.too_long;
  assign wb_pad_o   = wb_valid_o && pad_q;
  assign irq_rxb_o  = wb_valid_o;
  assign irq_rxf_o  = wb_last_o;
  assign busy_o     = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      err_q   <= '0;
      pad_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          rem_q   <= size_w;
          err_q   <= err_w;
          pad_q   <= shift16_i;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          if (desc_empty_i) begin
            rem_q <= after_w;
            pad_q <= 1'b0;
            if (last_w) state_q <= ST_ARM;
          end else begin
            state_q <= ST_ARM;  // drop the rest of the frame
          end
        end
        ST_ARM:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_trunc_long_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_trunc_o) |-> wb_long_o);
  p_full_buf_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_last_o) |-> (wb_len_o == eff_w));
  p_crc_tail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_last_o && wb_len_o >= SZ_W'(4)) |-> (wb_crc_o == 3'd4));
  p_pad_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && $past(wb_valid_o)) |-> !wb_pad_o);
  p_frame_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_last_o |=> (!wb_valid_o && busy_o));
  p_lost_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |=> ##1 (!rx_active_o && !busy_o));
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!wb_valid_o && !lost_o));
endmodule

// File: tb/sim_rx_desc_writer.sv
module sim_rx_desc_writer;
  typedef struct packed {
    logic [15:0] len;
    logic        sh;
    logic [15:0] tlim;
    logic [15:0] slim;
    logic [13:0] mb;
    logic [7:0]  n;
    logic [15:0] last_len;
    logic [2:0]  crc;
    logic        tr;
    logic        lg;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'd60,   1'b0, 16'h7FF, 16'h5EE, 14'h040, 8'd1, 16'd64,   3'd4, 1'b0, 1'b0},
    '{16'd100,  1'b0, 16'h7FF, 16'h5EE, 14'h040, 8'd2, 16'd40,   3'd4, 1'b0, 1'b0},
    '{16'd61,   1'b0, 16'h7FF, 16'h5EE, 14'h040, 8'd2, 16'd1,    3'd1, 1'b0, 1'b0},
    '{16'd60,   1'b1, 16'h7FF, 16'h5EE, 14'h040, 8'd2, 16'd2,    3'd2, 1'b0, 1'b0},
    '{16'd3000, 1'b0, 16'h7FF, 16'h5EE, 14'h400, 8'd2, 16'd1023, 3'd4, 1'b1, 1'b1},
    '{16'd1600, 1'b0, 16'h7FF, 16'h5EE, 14'h400, 8'd2, 16'd580,  3'd4, 1'b0, 1'b1},
    '{16'd28,   1'b0, 16'h7FF, 16'h5EE, 14'h005, 8'd2, 16'd16,   3'd4, 1'b0, 1'b0},
    '{16'd60,   1'b0, 16'h7FF, 16'h5EE, 14'h047, 8'd1, 16'd64,   3'd4, 1'b0, 1'b0},
    '{16'd200,  1'b1, 16'd100, 16'h5EE, 14'h040, 8'd2, 16'd36,   3'd4, 1'b1, 1'b1},
    '{16'd97,   1'b0, 16'h7FF, 16'd100, 14'h040, 8'd2, 16'd37,   3'd4, 1'b0, 1'b1},
    '{16'd96,   1'b0, 16'h7FF, 16'd100, 14'h040, 8'd2, 16'd36,   3'd4, 1'b0, 1'b0}
  };

  logic clk = 0, rst_ni = 0;
  logic frame_valid = 0, shift16 = 0, arm = 0;
  logic [15:0] frame_len = 0, trunc_lim = 16'h7FF, rx_lim = 16'h5EE;
  logic [13:0] max_buf = 14'h040;
  logic empty_m [8];
  logic wrap_m [8];
  logic [2:0]  desc_idx;
  logic busy, active, wb_valid, wb_pad, wb_last, wb_trunc, wb_long, irq_rxb, irq_rxf, lost;
  logic [17:0] wb_len;
  logic [2:0]  wb_crc;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  rx_desc_writer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_valid_i(frame_valid), .frame_len_i(frame_len),
    .shift16_i(shift16), .trunc_lim_i(trunc_lim), .rx_lim_i(rx_lim), .max_buf_i(max_buf),
    .arm_i(arm), .desc_empty_i(empty_m[desc_idx]), .desc_wrap_i(wrap_m[desc_idx]),
    .desc_idx_o(desc_idx), .busy_o(busy), .rx_active_o(active), .wb_valid_o(wb_valid),
    .wb_len_o(wb_len), .wb_crc_o(wb_crc), .wb_pad_o(wb_pad), .wb_last_o(wb_last),
    .wb_trunc_o(wb_trunc), .wb_long_o(wb_long), .irq_rxb_o(irq_rxb), .irq_rxf_o(irq_rxf),
    .lost_o(lost));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_of(input logic [13:0] mb);
    int e = int'(mb & 14'h3FF0);
    return (e == 0) ? 16 : e;
  endfunction

  function automatic int step(input int i);
    return (wrap_m[i] || i == 7) ? 0 : i + 1;
  endfunction

  // n: writebacks, ll/lc/ltr/llg: fields of the final one, nl: lost pulses
  task automatic run_frame(input logic [15:0] len, input logic sh, input logic [15:0] tl,
                           input logic [15:0] sl, input logic [13:0] mb,
                           output int n, output int ll, output int lc,
                           output int ltr, output int llg, output int nl);
    int cyc = 0;
    n = 0; ll = -1; lc = -1; ltr = -1; llg = -1; nl = 0;
    @(negedge clk);
    frame_len = len; shift16 = sh; trunc_lim = tl; rx_lim = sl; max_buf = mb;
    frame_valid = 1;
    @(negedge clk);
    frame_valid = 0;
    if (busy) chk("R1 first writeback due one cycle after request", int'(wb_valid | lost), 1);
    while (busy && cyc < 60) begin
      if (wb_valid) begin
        chk("R7 rxb with each writeback", int'(irq_rxb), 1);
        chk("R6 pad only on first buffer", int'(wb_pad), (n == 0) ? int'(sh) : 0);
        chk("R7 rxf follows last", int'(irq_rxf), int'(wb_last));
        if (!wb_last) begin
          chk("R4 full buffer length", int'(wb_len), eff_of(mb));
          chk("R7 no flags before last", int'(wb_trunc | wb_long), 0);
        end else begin
          ll = int'(wb_len); lc = int'(wb_crc); ltr = int'(wb_trunc); llg = int'(wb_long);
        end
        n++;
      end
      if (lost) nl++;
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, ll, lc, tr, lg, nl, cur, exp_idx;
    for (int i = 0; i < 8; i++) begin empty_m[i] = 1; wrap_m[i] = (i == 7); end
    repeat (3) @(negedge clk);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset active", int'(active), 0);
    chk("R11 reset index", int'(desc_idx), 0);
    chk("R11 reset writeback", int'(wb_valid), 0);
    rst_ni = 1;
    @(negedge clk);

    // R1: not armed yet, request ignored
    run_frame(16'd60, 1'b0, 16'h7FF, 16'h5EE, 14'h040, n, ll, lc, tr, lg, nl);
    chk("R1 inactive request ignored", n, 0);
    chk("R1 index unchanged", int'(desc_idx), 0);

    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    chk("R9 arm loads empty bit", int'(active), 1);

    for (int v = 0; v < NV; v++) begin
      exp_idx = int'(desc_idx);
      for (int k = 0; k < int'(VECS[v].n); k++) exp_idx = step(exp_idx);
      run_frame(VECS[v].len, VECS[v].sh, VECS[v].tlim, VECS[v].slim, VECS[v].mb,
                n, ll, lc, tr, lg, nl);
      chk("R4 descriptor count", n, int'(VECS[v].n));
      chk("R4 last length", ll, int'(VECS[v].last_len));
      chk("R5 CRC bytes in last buffer", lc, int'(VECS[v].crc));
      chk("R2 truncated flag", tr, int'(VECS[v].tr));
      chk("R3 too-long flag", lg, int'(VECS[v].lg));
      chk("R8 index after frame", int'(desc_idx), exp_idx);
      chk("R9 active after frame", int'(active), 1);
    end

    // R8: wrap bit on a middle slot
    cur = int'(desc_idx);
    if (cur == 7) begin
      run_frame(16'd20, 1'b0, 16'h7FF, 16'h5EE, 14'h040, n, ll, lc, tr, lg, nl);
      cur = int'(desc_idx);
    end
    wrap_m[cur] = 1;
    run_frame(16'd20, 1'b0, 16'h7FF, 16'h5EE, 14'h040, n, ll, lc, tr, lg, nl);
    chk("R8 wrap to slot 0", int'(desc_idx), 0);
    wrap_m[cur] = (cur == 7);

    // R9: next descriptor filled -> receive-active drops
    empty_m[1] = 0;
    run_frame(16'd20, 1'b0, 16'h7FF, 16'h5EE, 14'h040, n, ll, lc, tr, lg, nl);
    chk("R9 single writeback", n, 1);
    chk("R9 active follows next empty bit", int'(active), 0);
    run_frame(16'd20, 1'b0, 16'h7FF, 16'h5EE, 14'h040, n, ll, lc, tr, lg, nl);
    chk("R1 request ignored while inactive", n, 0);
    chk("R1 index held", int'(desc_idx), 1);
    empty_m[1] = 1;
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
    chk("R9 re-arm", int'(active), 1);

    // R10: filled descriptor partway through a frame
    empty_m[2] = 0;
    run_frame(16'd100, 1'b0, 16'h7FF, 16'h5EE, 14'h040, n, ll, lc, tr, lg, nl);
    chk("R10 writebacks before loss", n, 1);
    chk("R10 lost pulse", nl, 1);
    chk("R10 no last marker", ll, -1);
    chk("R10 active cleared", int'(active), 0);
    chk("R10 index stays", int'(desc_idx), 2);
    empty_m[2] = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule